// File: doc/BRIEF.md
# Chainable Serial Channel Code Bank

This block takes 16-bit command words from a three-wire serial port and stores 10-bit codes in a bank of eighteen channel registers. All of the codes are also driven out in parallel. The port has three inputs: serial clock, serial data, and a frame enable that is active low. All three are sampled by a system clock that runs at least four times faster than the serial clock. Each input passes through a two-flop synchronizer, and edges are found by comparing one synchronized sample with the next.

Words arrive most significant bit first. The top bit is a test bit and must be zero. Below it sit a five-bit channel number and then the code. The shift register is only collected while the enable is low, and nothing changes in the bank until the enable goes high again. The last stage of the shift register is re-registered on each falling serial clock edge and driven on a serial output. This lets several devices share one port: each device's serial output feeds the next device's serial input, and one long frame loads all of them. The word sent first lands in the device farthest down the chain. Every device commits its word on the same enable rising edge.

Top module: `serial_chan_bank`

## Requirements
- R1: While the synchronized enable is low, each rising serial clock edge shifts serial data into the least significant end of a 16-bit shift register. The first bit sent therefore ends up as bit 15.
- R2: In a completed word, bit 15 is the test bit and must be 0, bits 14..10 are the channel number (0 to 17), and bits 9..0 are the code. Channel n's code is driven on `chan_code_o[n*10 +: 10]`.
- R3: A channel register changes only on a rising edge of the enable. At any other time the whole bank holds its value.
- R4: Serial clock edges have no effect on the shift register or the serial output while the enable is high.
- R5: The serial output takes bit 15 of the shift register on each falling serial clock edge inside a frame. A bit sent on the input appears at the output on the 16th falling edge after it was sent.
- R6: When a frame carries more than 16 bits, only the last 16 are written. The earlier bits leave through the serial output in order.
- R7: A word whose test bit is 1 leaves every channel unchanged.
- R8: A word whose channel number is 18 through 31 leaves every channel unchanged.
- R9: A frame with fewer than 16 rising serial clock edges is discarded when the enable rises.
- R10: Synchronous reset clears every channel, the shift register and the bit count to zero, and drives the serial output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data, sampled on the rising serial clock edge |
| ser_en_n_i | input | 1 | Frame enable, active low; its rising edge commits the word |
| ser_dat_o | output | 1 | Chain output: last shift stage, updated on the falling serial clock edge |
| chan_code_o | output | 180 | Eighteen 10-bit channel codes; channel n at bits n*10+9..n*10 |

## Verification
The hardest state to reach from the ports is a frame that mixes history with new data. In one case a frame carries two words, so the first word must leave on the serial output while only the second is written. In the other case the shift register still holds a complete, valid-looking word from an earlier frame, and a short frame or stray clocks while the enable is high would corrupt it.

The bench builds 32-bit frames and records the serial output after every falling edge. It sends a 15-bit frame whose contents, if they were accepted, would form a valid write. It also toggles the serial clock while the enable is high and then reads back the untouched register contents through the serial output during the next frame.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned TEST_BIT = WORD_W - 1;
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [WORD_W-1:0] w);
    return w[CODE_W +: ADDR_W];
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic word_ok(input logic [WORD_W-1:0] w, input int unsigned nch);
    return (w[TEST_BIT] == 1'b0) && (int'(word_addr(w)) < int'(nch));
  endfunction
endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign sync_o = stg[STAGES-1];
  assign rise_o = sync_o & ~prev;
  assign fall_o = ~sync_o & prev;
endmodule

// File: rtl/scb_shifter.sv
module scb_shifter
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              en_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  output logic [WORD_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              sdo_o
);
  logic shift_ev;
  logic pass_ev;

  assign shift_ev = sclk_rise & ~en_n;
  assign pass_ev  = sclk_fall & ~en_n;
  assign full_o   = (cnt_o == CNT_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_o <= '0;
      cnt_o   <= '0;
      sdo_o   <= 1'b0;
    end else begin
      if (shift_ev) shreg_o <= {shreg_o[WORD_W-2:0], sdi};
      if (en_fall) cnt_o <= shift_ev ? CNT_W'(1) : '0;
      else if (shift_ev && !full_o) cnt_o <= cnt_o + 1'b1;
      if (pass_ev) sdo_o <= shreg_o[WORD_W-1];
    end
  end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
  import scb_pkg::*;
#(
  parameter int unsigned NUM_CH = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_code,
  output logic [NUM_CH*CODE_W-1:0] codes_o
);
  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g))) code_q <= wr_code;
    end
    assign codes_o[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/serial_chan_bank.sv
module serial_chan_bank
  import scb_pkg::*;
#(
  parameter int unsigned NUM_CH = 18,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BANK_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_en_n_i,
  output logic              ser_dat_o,
  output logic [BANK_W-1:0] chan_code_o
);
  localparam int unsigned IDX_CLK = 0;
  localparam int unsigned IDX_DAT = 1;
  localparam int unsigned IDX_EN  = 2;

  logic [2:0] sync_v, rise_v, fall_v;
  logic sclk_rise, sclk_fall, en_n_s, en_rise, en_fall, sdi_s;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic full;
  logic commit;

  scb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .din({ser_en_n_i, ser_dat_i, ser_clk_i}),
    .sync_o(sync_v), .rise_o(rise_v), .fall_o(fall_v)
  );

  assign sclk_rise = rise_v[IDX_CLK];
  assign sclk_fall = fall_v[IDX_CLK];
  assign sdi_s     = sync_v[IDX_DAT];
  assign en_n_s    = sync_v[IDX_EN];
  assign en_rise   = rise_v[IDX_EN];
  assign en_fall   = fall_v[IDX_EN];

  scb_shifter u_shift (
    .clk(clk), .rst(rst), .en_n(en_n_s), .en_fall(en_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi(sdi_s),
    .shreg_o(shreg), .cnt_o(cnt), .full_o(full), .sdo_o(ser_dat_o)
  );

  assign commit = en_rise & full & word_ok(shreg, NUM_CH);

  scb_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .wr_en(commit),
    .wr_addr(word_addr(shreg)), .wr_code(word_code(shreg)),
    .codes_o(chan_code_o)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker
  import scb_pkg::*;
#(
  parameter int unsigned NUM_CH = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en_n_s,
  input logic                     en_rise,
  input logic                     sclk_fall,
  input logic                     commit,
  input logic [CNT_W-1:0]         cnt,
  input logic [WORD_W-1:0]        shreg,
  input logic [NUM_CH*CODE_W-1:0] bank,
  input logic                     sdo
);
  AST_COMMIT_ON_EN_RISE: assert property (@(posedge clk) disable iff (rst) commit |-> en_rise); // R3
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(bank)); // R3
  AST_NO_SHIFT_EN_HIGH: assert property (@(posedge clk) disable iff (rst) en_n_s |=> $stable(shreg)); // R4
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst) !(sclk_fall && !en_n_s) |=> $stable(sdo)); // R5
  AST_TEST_BIT_BLOCKS: assert property (@(posedge clk) disable iff (rst) shreg[TEST_BIT] |-> !commit); // R7
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) (int'(shreg[CODE_W +: ADDR_W]) >= int'(NUM_CH)) |-> !commit); // R8
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (rst) (cnt < CNT_W'(WORD_W)) |-> !commit); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(WORD_W)); // R9
endmodule

bind serial_chan_bank scb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .en_n_s(en_n_s), .en_rise(en_rise),
  .sclk_fall(sclk_fall), .commit(commit), .cnt(cnt), .shreg(shreg),
  .bank(chan_code_o), .sdo(ser_dat_o)
);

// File: tb/test_serial_chan_bank.sv
module test_serial_chan_bank;
  localparam int NCH = 18;
  localparam int CW = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, en_n = 1'b1;
  logic sdo;
  logic [NCH*CW-1:0] codes;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [CW-1:0] model [NCH];
  logic sdo_log [64];

  always #2.5 clk = ~clk;

  serial_chan_bank i_serial_chan_bank (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdi),
    .ser_en_n_i(en_n), .ser_dat_o(sdo), .chan_code_o(codes)
  );

  // word: {exp_write, 16-bit word}; bit15 test, 14..10 channel, 9..0 code
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'h02A5}, {1'b1, 16'h47FF}, {1'b1, 16'h1523}, {1'b0, 16'h94AA},
    {1'b0, 16'h4955}, {1'b0, 16'h7FC3}, {1'b1, 16'h1401}, {1'b1, 16'h2600}
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] model_flat();
    logic [NCH*CW-1:0] f;
    for (int n = 0; n < NCH; n++) f[n*CW +: CW] = model[n];
    return f;
  endfunction

  task automatic frame(input logic [63:0] bits, input int n);
    @(negedge clk);
    en_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      sdo_log[i] = sdo;
      @(negedge clk);
    end
    en_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [15:0] a_w, b_w;
    logic ok;
    for (int n = 0; n < NCH; n++) model[n] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 bank after reset", 256'(codes), 256'(0));
    check("R10 sdo after reset", 256'(sdo), 256'(0));

    // R1 R2 R7 R8: vector walk
    for (int v = 0; v < 8; v++) begin
      w = VEC[v][15:0];
      frame(64'(w), 16);
      if (VEC[v][16]) model[w[14:10]] = w[9:0];
      check(VEC[v][16] ? "R1 R2 addressed write" : "R7 R8 rejected word",
            256'(codes), 256'(model_flat()));
    end

    // R6 R5: two words in one frame; only the second is written
    a_w = 16'h0D11;
    b_w = 16'h10F0;
    frame({32'h0, a_w, b_w}, 32);
    model[4] = 10'h0F0;
    check("R6 long frame uses final word", 256'(codes), 256'(model_flat()));
    ok = 1'b1;
    for (int k = 16; k <= 31; k++)
      if (sdo_log[k-1] !== a_w[15-(k-16)]) ok = 1'b0;
    check("R5 R6 first word passed on serial out", 256'(ok), 256'(1));

    // R9: 15-bit frame that would otherwise form a valid write to channel 2
    frame(64'(16'h0955 & 16'h7FFF), 15);
    check("R9 short frame discarded", 256'(codes), 256'(model_flat()));

    // R4: clocks while enable high must not disturb the register or serial out
    w = 16'h0003;
    frame(64'(w), 16);
    model[0] = 10'h003;
    begin
      logic sdo_before;
      sdo_before = sdo;
      sdi = 1'b1;
      for (int t = 0; t < 20; t++) begin
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
      repeat (10) @(negedge clk);
      check("R4 sdo unchanged with enable high", 256'(sdo), 256'(sdo_before));
      check("R3 R4 bank unchanged by clocks with enable high", 256'(codes), 256'(model_flat()));
    end
    frame(64'(16'h0555), 16);
    model[1] = 10'h155;
    ok = 1'b1;
    for (int k = 1; k <= 15; k++)
      if (sdo_log[k-1] !== w[15-k]) ok = 1'b0;
    check("R4 register contents kept across idle clocks", 256'(ok), 256'(1));
    check("R2 channel 1 written", 256'(codes[1*CW +: CW]), 256'(10'h155));

    // R10: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 bank cleared by reset", 256'(codes), 256'(0));
    check("R10 sdo low after reset", 256'(sdo), 256'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule